// File: doc/BRIEF.md
# MSI L1 Child Coherence Controller

This block is a direct-mapped first-level cache controller that acts as a child under a parent directory in a two-level invalidation protocol. Each line is in Invalid (I), Shared (S) or Modified (M), and these states are ordered I < S < M. Processor loads and stores are served from the line array when the line has enough permission. Otherwise the controller asks the parent for the state it needs and holds the processor request until the parent answers.

The parent can ask the child to drop a line to a lower state. The child answers such a request, writing back the word if it held it in M, or consumes the request silently if its state is already low enough. When a miss needs a slot whose line still holds another address, the child first gives that line up to I on its own initiative and then retags the slot. Each line carries an awaited-state marker instead of a valid bit. While the marker is set, the line does not issue a second upgrade.

There are three message paths. Messages from the parent arrive on one valid/ready channel. Messages to the parent leave on two separate valid/ready channels, one for requests and one for responses, so a stalled request never blocks a response. Each message carries an address, a target state and, where it applies, one data word.

Top module: `msi_l1_child`

## Requirements
- R1: After reset every line is in I with no pending upgrade, and no response, request or processor reply is valid.
- R2: A load whose tag matches a line in S or M is accepted at once. Its data appears on the processor reply exactly one cycle after acceptance, and no message goes to the parent.
- R3: A store is accepted at once only when the line's tag matches and the line is in M. It writes the word, and the reply one cycle later carries data 0.
- R4: State codes on every channel are I=0, S=1 and M=2, and the line index is address bits [5:2]. A miss on a line in I with nothing pending rewrites the tag and sends one request carrying the full address and target S for a load or M for a store.
- R5: A store to a matching line in S with nothing pending sends a request for M to the same address without retagging, and the store completes after the grant.
- R6: A grant from the parent sets the line to the granted state and clears the pending marker. It loads the carried word only if the line was in I. The stalled processor request then completes.
- R7: A parent downgrade to y for a matching line whose state is above y returns a response with the address and y. The response carries the word (data flag 1) only when the line was in M, and the line then moves to y.
- R8: A parent downgrade whose tag mismatches, or whose line is already at or below y, is accepted and produces no response and no state change.
- R9: A miss on a slot holding another address in S or M, with nothing pending, first sends a voluntary response to I for the old address, with the word only from M, and then requests the new address.
- R10: A valid request or response to the parent holds its contents until accepted. A response can leave while the request channel is held not ready.
- R11: While a line awaits a grant, no further request for it is sent, and the processor request stalls without replies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| preq_valid | input | 1 | Processor request present |
| preq_ready | output | 1 | Processor request accepted this cycle |
| preq_store | input | 1 | 1 for store, 0 for load |
| preq_addr | input | 32 | Byte address of the word |
| preq_wdata | input | 32 | Store data |
| presp_valid | output | 1 | Processor reply pulse |
| presp_data | output | 32 | Load data, 0 for a store acknowledge |
| creq_valid | output | 1 | Upgrade request to parent valid |
| creq_ready | input | 1 | Parent takes the request |
| creq_addr | output | 32 | Request address |
| creq_state | output | 2 | Requested state |
| crsp_valid | output | 1 | Downgrade response to parent valid |
| crsp_ready | input | 1 | Parent takes the response |
| crsp_addr | output | 32 | Response address |
| crsp_state | output | 2 | State the line moved to |
| crsp_has_data | output | 1 | Word is carried |
| crsp_data | output | 32 | Written-back word |
| pmsg_valid | input | 1 | Message from parent present |
| pmsg_ready | output | 1 | Message from parent consumed |
| pmsg_is_resp | input | 1 | 1 for a grant, 0 for a downgrade request |
| pmsg_addr | input | 32 | Message address |
| pmsg_state | input | 2 | Granted or target state |
| pmsg_data | input | 32 | Word carried by a grant |

## Verification
A wrong line state or tag shows up at the ports within a few cycles. It appears as an extra or missing request to the parent on the next access, as a load that stalls when it should hit, or as a downgrade that is answered when it should be dropped. Lost data from a missing write-back surfaces later, when the bench's parent memory serves a stale word on a re-fetch, so the bench compares load data with a reference image of every store. A stuck pending marker shows as a processor request that never completes.

// File: rtl/msi_l1_child.sv
module msi_l1_child #(
  parameter int LINES = 16,
  parameter int AW    = 32,
  parameter int DW    = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          preq_valid,
  output logic          preq_ready,
  input  logic          preq_store,
  input  logic [AW-1:0] preq_addr,
  input  logic [DW-1:0] preq_wdata,
  output logic          presp_valid,
  output logic [DW-1:0] presp_data,
  output logic          creq_valid,
  input  logic          creq_ready,
  output logic [AW-1:0] creq_addr,
  output logic [1:0]    creq_state,
  output logic          crsp_valid,
  input  logic          crsp_ready,
  output logic [AW-1:0] crsp_addr,
  output logic [1:0]    crsp_state,
  output logic          crsp_has_data,
  output logic [DW-1:0] crsp_data,
  input  logic          pmsg_valid,
  output logic          pmsg_ready,
  input  logic          pmsg_is_resp,
  input  logic [AW-1:0] pmsg_addr,
  input  logic [1:0]    pmsg_state,
  input  logic [DW-1:0] pmsg_data
);
  localparam int IW = $clog2(LINES);
  localparam int TW = AW - 2 - IW;
  localparam logic [1:0] ST_I = 2'd0, ST_S = 2'd1, ST_M = 2'd2;

  logic [TW-1:0] tag_q [LINES];
  logic [1:0]    st_q  [LINES];
  logic [1:0]    wt_q  [LINES];
  logic [DW-1:0] dat_q [LINES];

  logic [IW-1:0] p_idx, c_idx;
  logic [TW-1:0] p_tag, c_tag;
  logic          dn_act, p_fire;
  logic [1:0]    need, c_st;
  logic          c_match, c_hit, busy, can_up, do_evict;
  logic          unused_lsb;

  assign unused_lsb = ^{preq_addr[1:0], pmsg_addr[1:0]};

  assign p_idx  = pmsg_addr[IW+1:2];
  assign p_tag  = pmsg_addr[AW-1:IW+2];
  assign dn_act = !pmsg_is_resp && (tag_q[p_idx] == p_tag) && (st_q[p_idx] > pmsg_state);
  assign pmsg_ready = pmsg_is_resp || !dn_act || !crsp_valid;
  assign p_fire = pmsg_valid && pmsg_ready;

  assign c_idx   = preq_addr[IW+1:2];
  assign c_tag   = preq_addr[AW-1:IW+2];
  assign need    = preq_store ? ST_M : ST_S;
  assign c_st    = st_q[c_idx];
  assign c_match = tag_q[c_idx] == c_tag;
  assign c_hit   = c_match && (preq_store ? (c_st == ST_M) : (c_st != ST_I));
  assign busy    = pmsg_valid;
  assign preq_ready = !busy && c_hit;
  assign can_up  = !busy && preq_valid && !c_hit && (wt_q[c_idx] == ST_I) &&
                   (c_match || c_st == ST_I) && !creq_valid;
  assign do_evict = !busy && preq_valid && !c_match && (c_st != ST_I) &&
                    (wt_q[c_idx] == ST_I) && !crsp_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < LINES; i++) begin
        tag_q[i] <= '0;
        st_q[i]  <= ST_I;
        wt_q[i]  <= ST_I;
        dat_q[i] <= '0;
      end
      presp_valid   <= 1'b0;
      presp_data    <= '0;
      creq_valid    <= 1'b0;
      creq_addr     <= '0;
      creq_state    <= ST_I;
      crsp_valid    <= 1'b0;
      crsp_addr     <= '0;
      crsp_state    <= ST_I;
      crsp_has_data <= 1'b0;
      crsp_data     <= '0;
    end else begin
      presp_valid <= preq_valid && preq_ready;
      if (preq_valid && preq_ready) begin
        presp_data <= preq_store ? '0 : dat_q[c_idx];
        if (preq_store) dat_q[c_idx] <= preq_wdata;
      end

      if (creq_valid && creq_ready) creq_valid <= 1'b0;
      if (can_up) begin
        creq_valid   <= 1'b1;
        creq_addr    <= preq_addr;
        creq_state   <= need;
        wt_q[c_idx]  <= need;
        if (!c_match) tag_q[c_idx] <= c_tag;
      end

      if (crsp_valid && crsp_ready) crsp_valid <= 1'b0;
      if (p_fire && dn_act) begin
        crsp_valid    <= 1'b1;
        crsp_addr     <= pmsg_addr;
        crsp_state    <= pmsg_state;
        crsp_has_data <= st_q[p_idx] == ST_M;
        crsp_data     <= (st_q[p_idx] == ST_M) ? dat_q[p_idx] : '0;
        st_q[p_idx]   <= pmsg_state;
      end else if (do_evict) begin
        crsp_valid    <= 1'b1;
        crsp_addr     <= {tag_q[c_idx], c_idx, 2'b00};
        crsp_state    <= ST_I;
        crsp_has_data <= c_st == ST_M;
        crsp_data     <= (c_st == ST_M) ? dat_q[c_idx] : '0;
        st_q[c_idx]   <= ST_I;
      end

      if (p_fire && pmsg_is_resp) begin
        if (st_q[p_idx] == ST_I) dat_q[p_idx] <= pmsg_data;
        st_q[p_idx] <= pmsg_state;
        wt_q[p_idx] <= ST_I;
      end
    end
  end
endmodule

// File: rtl/msi_l1_child_chk.sv
module msi_l1_child_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        preq_valid,
  input logic        preq_ready,
  input logic        preq_store,
  input logic        presp_valid,
  input logic [31:0] presp_data,
  input logic        creq_valid,
  input logic        creq_ready,
  input logic [31:0] creq_addr,
  input logic [1:0]  creq_state,
  input logic        crsp_valid,
  input logic        crsp_ready,
  input logic [31:0] crsp_addr,
  input logic [1:0]  crsp_state,
  input logic        pmsg_valid,
  input logic        pmsg_ready,
  input logic        pmsg_is_resp
);
  a_r10_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    creq_valid && !creq_ready |=> creq_valid && $stable(creq_addr) && $stable(creq_state));

  a_r10_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    crsp_valid && !crsp_ready |=> crsp_valid && $stable(crsp_addr) && $stable(crsp_state));

  a_r6_grant_taken: assert property (@(posedge clk) disable iff (!rst_n)
    pmsg_valid && pmsg_is_resp |-> pmsg_ready);

  a_r2_reply_follows: assert property (@(posedge clk) disable iff (!rst_n)
    presp_valid |-> $past(preq_valid && preq_ready));

  a_r3_store_ack_zero: assert property (@(posedge clk) disable iff (!rst_n)
    presp_valid && $past(preq_store) |-> presp_data == 32'd0);

  a_r4_req_state: assert property (@(posedge clk) disable iff (!rst_n)
    creq_valid |-> (creq_state == 2'd1 || creq_state == 2'd2));

  a_r7_rsp_below_m: assert property (@(posedge clk) disable iff (!rst_n)
    crsp_valid |-> (crsp_state == 2'd0 || crsp_state == 2'd1));
endmodule

bind msi_l1_child msi_l1_child_chk i_chk (.*);

// File: tb/test_msi_l1_child.sv
`timescale 1ns/1ps
module test_msi_l1_child;
  logic clk = 1'b0, rst_n = 1'b0;
  logic preq_valid = 0, preq_store = 0;
  logic [31:0] preq_addr = 0, preq_wdata = 0;
  logic preq_ready, presp_valid;
  logic [31:0] presp_data;
  logic creq_valid, creq_ready = 1'b1;
  logic [31:0] creq_addr;
  logic [1:0] creq_state;
  logic crsp_valid, crsp_ready = 1'b1, crsp_has_data;
  logic [31:0] crsp_addr, crsp_data;
  logic [1:0] crsp_state;
  logic pmsg_valid = 0, pmsg_is_resp = 0, pmsg_ready;
  logic [31:0] pmsg_addr = 0, pmsg_data = 0;
  logic [1:0] pmsg_state = 0;

  always #2.5 clk = ~clk;

  msi_l1_child i_msi_l1_child (.*);

  int checks = 0, fails = 0, pcount = 0, ops = 0;
  logic [66:0] p2c_q [$];
  logic [33:0] req_log [$];
  logic [66:0] rsp_log [$];
  logic [31:0] pmem [logic [31:0]];
  bit p2c_fire = 0;

  function automatic logic [31:0] rdmem(input logic [31:0] a);
    return pmem.exists(a) ? pmem[a] : (a ^ 32'h5A5A_0000);
  endfunction

  task automatic check(input bit ok, input string tag, input logic [66:0] act, input logic [66:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    p2c_fire <= pmsg_valid && pmsg_ready;
    if (rst_n && crsp_valid && crsp_ready) begin
      rsp_log.push_back({crsp_has_data, crsp_addr, crsp_state, crsp_data});
      if (crsp_has_data) pmem[crsp_addr] = crsp_data;
    end
    if (rst_n && creq_valid && creq_ready) begin
      req_log.push_back({creq_addr, creq_state});
      p2c_q.push_back({1'b1, creq_addr, creq_state, rdmem(creq_addr)});
    end
  end

  always @(negedge clk) begin
    if (p2c_fire) void'(p2c_q.pop_front());
    if (p2c_q.size() > 0) begin
      pmsg_valid = 1'b1;
      {pmsg_is_resp, pmsg_addr, pmsg_state, pmsg_data} = p2c_q[0];
    end else pmsg_valid = 1'b0;
    if (presp_valid) pcount++;
  end

  task automatic proc(input bit st, input logic [31:0] a, input logic [31:0] wd,
                      output logic [31:0] rd, output int tries);
    bit acc;
    @(negedge clk); #1;
    preq_valid = 1'b1; preq_store = st; preq_addr = a; preq_wdata = wd;
    tries = 0; ops++;
    while (1) begin
      #1 acc = preq_ready;
      tries++;
      @(negedge clk);
      if (acc) begin
        check(presp_valid === 1'b1, "R2 reply one cycle after acceptance", 67'(presp_valid), 67'd1);
        rd = presp_data;
        #1 preq_valid = 1'b0;
        break;
      end
      #1;
    end
  endtask

  task automatic down(input logic [31:0] a, input logic [1:0] y);
    @(negedge clk); #1;
    p2c_q.push_back({1'b0, a, y, 32'd0});
    repeat (6) @(negedge clk);
  endtask

  task automatic finish_up;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual expired expected done");
    finish_up();
  end

  localparam logic [31:0] A = 32'h0000_1000, B = 32'h0000_2000;
  localparam logic [31:0] C = 32'h0000_1008, D = 32'h0000_1004;

  initial begin
    logic [31:0] rd;
    int tries, nreq, nrsp;
    repeat (3) @(negedge clk);
    check(!creq_valid && !crsp_valid && !presp_valid, "R1 reset outputs idle",
          67'({creq_valid, crsp_valid, presp_valid}), 67'd0);
    #1 rst_n = 1'b1;

    proc(0, A, 0, rd, tries);
    check(rd == rdmem(A), "R6 fill from I loads granted word", 67'(rd), 67'(rdmem(A)));
    check(req_log.size() == 1 && req_log[0] == {A, 2'd1}, "R4 load miss requests S",
          67'(req_log.size() > 0 ? req_log[0] : 34'd0), 67'({A, 2'd1}));
    proc(0, A, 0, rd, tries);
    check(tries == 1 && req_log.size() == 1, "R2 load hit in S", 67'(tries), 67'd1);

    proc(1, A, 32'h1111_1111, rd, tries);
    check(req_log.size() == 2 && req_log[1] == {A, 2'd2}, "R5 S store upgrades to M",
          67'(req_log[req_log.size()-1]), 67'({A, 2'd2}));
    check(rd == 0, "R3 store ack data", 67'(rd), 67'd0);
    proc(1, A, 32'h2222_2222, rd, tries);
    check(tries == 1 && req_log.size() == 2, "R3 store hit in M", 67'(tries), 67'd1);
    proc(0, A, 0, rd, tries);
    check(rd == 32'h2222_2222, "R3 stored word read back", 67'(rd), 67'h2222_2222);

    down(A, 2'd1);
    check(rsp_log.size() == 1 && rsp_log[0] == {1'b1, A, 2'd1, 32'h2222_2222},
          "R7 M to S downgrade with data", rsp_log.size() > 0 ? rsp_log[0] : 67'd0,
          {1'b1, A, 2'd1, 32'h2222_2222});
    proc(0, A, 0, rd, tries);
    check(tries == 1 && rd == 32'h2222_2222, "R2 load hit after downgrade to S", 67'(rd), 67'h2222_2222);
    down(A, 2'd1);
    down(B, 2'd0);
    check(rsp_log.size() == 1 && p2c_q.size() == 0, "R8 satisfied or mismatched downgrade dropped",
          67'(rsp_log.size()), 67'd1);
    proc(0, A, 0, rd, tries);
    check(tries == 1 && req_log.size() == 2, "R8 dropped downgrade leaves line in S", 67'(tries), 67'd1);

    down(A, 2'd0);
    check(rsp_log.size() == 2 && rsp_log[1] == {1'b0, A, 2'd0, 32'd0}, "R7 S to I downgrade without data",
          rsp_log[rsp_log.size()-1], {1'b0, A, 2'd0, 32'd0});
    proc(0, A, 0, rd, tries);
    check(req_log.size() == 3 && req_log[2] == {A, 2'd1} && rd == 32'h2222_2222,
          "R4 refetch after invalidation", 67'(rd), 67'h2222_2222);

    proc(1, A, 32'h3333_3333, rd, tries);
    proc(0, B, 0, rd, tries);
    check(rsp_log.size() == 3 && rsp_log[2] == {1'b1, A, 2'd0, 32'h3333_3333}, "R9 eviction of M line",
          rsp_log[rsp_log.size()-1], {1'b1, A, 2'd0, 32'h3333_3333});
    check(req_log[req_log.size()-1] == {B, 2'd1} && rd == rdmem(B), "R9 new tag requested after eviction",
          67'(req_log[req_log.size()-1]), 67'({B, 2'd1}));
    proc(0, A, 0, rd, tries);
    check(rsp_log.size() == 4 && rsp_log[3] == {1'b0, B, 2'd0, 32'd0} && rd == 32'h3333_3333,
          "R9 eviction of S line and write-back seen", 67'(rd), 67'h3333_3333);

    proc(1, D, 32'h4444_4444, rd, tries);
    nreq = req_log.size(); nrsp = rsp_log.size();
    creq_ready = 1'b0;
    fork
      proc(0, C, 0, rd, tries);
      begin
        repeat (4) @(negedge clk);
        check(creq_valid && creq_addr == C && creq_state == 2'd1, "R10 blocked request held",
              67'({creq_valid, creq_addr}), 67'({1'b1, C}));
        down(D, 2'd0);
        check(rsp_log.size() == nrsp + 1 && rsp_log[nrsp] == {1'b1, D, 2'd0, 32'h4444_4444},
              "R10 response passes blocked request", rsp_log[rsp_log.size()-1], {1'b1, D, 2'd0, 32'h4444_4444});
        check(req_log.size() == nreq && !presp_valid, "R11 no extra request while pending",
              67'(req_log.size()), 67'(nreq));
        #1 creq_ready = 1'b1;
      end
    join
    check(rd == rdmem(C) && req_log.size() == nreq + 1, "R11 single request per miss",
          67'(req_log.size()), 67'(nreq + 1));
    repeat (3) @(negedge clk);
    check(pcount == ops, "R2 reply count matches accepted requests", 67'(pcount), 67'(ops));
    finish_up();
  end
endmodule